// File: doc/BRIEF.md
# Prioritized Event Interrupt Controller

This block gathers single-cycle event pulses from up to eight sound-subsystem sources into a pending mask. It drives a fast-interrupt request to a host processor for as long as any event is pending. It also keeps an event-number register that software reads to learn which event to service. The periodic timer source uses event number 2, and a second general source uses event number 5. Any source may pulse in any cycle, and several may pulse in the same cycle.

Software acknowledges events by writing to a clear address. The block acts only on every fourth such write. On that write it drops the lowest-numbered pending event and points the event-number register at the next pending event. When nothing is pending any more, the interrupt line falls, but the event-number register keeps its last value. The event-number register is updated under these rules:

- When an event arrives, the register takes the new event's number if it holds zero or a number larger than the new one.
- Otherwise the register keeps its value.
- Its reset value is 1.

The register bus always accepts a request in the cycle it is presented. There is no back-pressure, and no request is ever stalled or dropped.

Top module: `evt_irq_ctrl`

## Requirements
- R1: An event pulse on input bit n sets pending bit n. Each pending event is dropped by exactly one completed acknowledge, lowest number first.
- R2: The interrupt output is high in the cycle after any event pulse. It stays high while any pending bit is set.
- R3: When an event arrives, the event-number register takes its number if the register holds 0 or a larger number. Otherwise the register is unchanged. Among events that pulse together, the lowest-numbered one is the candidate.
- R4: Each write to word address 0xD04 advances a 2-bit acknowledge count. The first, second and third writes have no effect on the pending state or on the event number.
- R5: The fourth write clears the lowest set pending bit and resets the count to zero. If any bit is still pending, the event-number register then takes the lowest remaining pending number.
- R6: When a completed acknowledge leaves the pending mask empty, the interrupt output falls in the next cycle and the event-number register keeps its value.
- R7: A read of word address 0xD00 returns the event number in read-data bits 2:0, with all upper bits zero, one cycle after the request. After reset the value is 1.
- R8: Writes to 0xD04 are not stored. A read of any address other than 0xD00 returns zero.
- R9: When an event pulse and a fourth clear write fall in the same cycle, the clear is applied first and the new event is then set. The new event is never lost.
- R10: Reset empties the pending mask, zeroes the acknowledge count, drops the interrupt output and sets the event number to 1.
- R11: Writes to other addresses and reads do not advance the acknowledge count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | 8 | One-cycle event pulses, bit n is event n |
| bus_valid | input | 1 | Bus request present, always accepted |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Word address |
| bus_wdata | input | 32 | Write data (ignored by this block) |
| bus_rdata | output | 32 | Read data, valid one cycle after a read request |
| irq_fast | output | 1 | Fast-interrupt request to the host |

## Verification
The following results all appear one clock edge after the input that causes them, because each passes through a single register:
- the interrupt line after an event pulse or a completed acknowledge;
- the event number after an event pulse or a completed acknowledge;
- the read data after a read request.

The bench applies every stimulus at a falling edge, so it is settled when the rising edge captures it. The bench then samples at the following falling edge, which is the first point where the result is due. Reads are issued only in cycles that carry no event, so the value returned is the state in place before that read.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  typedef enum logic [1:0] {
    BUS_IDLE   = 2'd0,
    BUS_RD_NUM = 2'd1,
    BUS_CLR_WR = 2'd2,
    BUS_OTHER  = 2'd3
  } bus_cmd_e;

  localparam int unsigned TIMER_EVT_ID   = 2;
  localparam int unsigned GENERAL_EVT_ID = 5;

  localparam logic [11:0] NUM_REG_ADDR = 12'hD00;
  localparam logic [11:0] CLR_REG_ADDR = 12'hD04;

endpackage

// File: rtl/evt_prio_enc.sv
module evt_prio_enc #(
  parameter int unsigned W  = 8,
  parameter int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);

  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/evt_ack_seq.sv
module evt_ack_seq #(
  parameter int unsigned ACK_WRITES = 4,
  localparam int unsigned CNT_W = (ACK_WRITES > 1) ? $clog2(ACK_WRITES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_wr,
  output logic fire
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(ACK_WRITES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign fire = clr_wr && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_wr) begin
      cnt_q <= fire ? '0 : cnt_q + 1'b1;
    end
  end

  // R5: count returns to zero after the completing write
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt_q == '0));

  // R11: the count moves only on clear writes
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> $stable(cnt_q));

  // R4: a clear write below the last one advances by one
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !fire) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/evt_pend_track.sv
module evt_pend_track #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pulse,
  input  logic         fire,
  output logic [N-1:0] after_clr,
  output logic         irq
);

  logic [N-1:0] pend_q;
  logic [N-1:0] low_hot;
  logic [N-1:0] pend_d;

  assign low_hot = pend_q & (~pend_q + 1'b1);

  for (genvar g = 0; g < N; g++) begin : g_bit
    assign after_clr[g] = pend_q[g] & ~(fire & low_hot[g]);
    assign pend_d[g]    = after_clr[g] | pulse[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign irq = |pend_q;

  // R2: any event raises the interrupt next cycle
  p_irq_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|pulse) |=> irq);

  // R9: new events survive a same-cycle clear
  p_no_loss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|pulse) |=> ((pend_q & $past(pulse)) == $past(pulse)));

  // R5: a completed acknowledge drops exactly one bit
  p_drop_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (|pend_q) && !(|pulse)) |=>
      ($countones(pend_q) == $countones($past(pend_q)) - 1));

  // R1: without events or acknowledge the mask holds
  p_mask_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !(|pulse)) |=> $stable(pend_q));

endmodule

// File: rtl/evt_num_reg.sv
module evt_num_reg #(
  parameter int unsigned IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          nxt_found,
  input  logic [IW-1:0] nxt_idx,
  input  logic          new_found,
  input  logic [IW-1:0] new_idx,
  output logic [IW-1:0] num_q
);

  logic [IW-1:0] num_clr;
  logic [IW-1:0] num_d;

  always_comb begin
    num_clr = (fire && nxt_found) ? nxt_idx : num_q;
    num_d   = num_clr;
    if (new_found && ((num_clr == '0) || (new_idx < num_clr))) num_d = new_idx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) num_q <= IW'(1);
    else        num_q <= num_d;
  end

  // R3: a lower (or first) event number is taken
  p_take_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (new_found && !fire && ((num_q == '0) || (new_idx < num_q))) |=>
      (num_q == $past(new_idx)));

  // R3: a higher event number leaves the register alone
  p_keep_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && (num_q != '0) && (!new_found || (new_idx >= num_q))) |=>
      $stable(num_q));

  // R6: emptying the mask keeps the last number
  p_keep_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !nxt_found && !new_found) |=> $stable(num_q));

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int unsigned N_EVT      = 8,
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ACK_WRITES = 4,
  parameter logic [ADDR_W-1:0] NUM_ADDR = ADDR_W'(NUM_REG_ADDR),
  parameter logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(CLR_REG_ADDR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EVT-1:0]  evt_pulse,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_fast
);

  localparam int unsigned IW = (N_EVT > 1) ? $clog2(N_EVT) : 1;

  bus_cmd_e       cmd;
  logic           fire;
  logic [N_EVT-1:0] after_clr;
  logic           nxt_found, new_found;
  logic [IW-1:0]  nxt_idx, new_idx;
  logic [IW-1:0]  num_q;
  logic           unused_wdata;

  assign unused_wdata = ^bus_wdata;

  always_comb begin
    cmd = BUS_IDLE;
    if (bus_valid) begin
      if (bus_we && bus_addr == CLR_ADDR)       cmd = BUS_CLR_WR;
      else if (!bus_we && bus_addr == NUM_ADDR) cmd = BUS_RD_NUM;
      else                                      cmd = BUS_OTHER;
    end
  end

  evt_ack_seq #(.ACK_WRITES(ACK_WRITES)) u_ack (
    .clk(clk), .rst_n(rst_n), .clr_wr(cmd == BUS_CLR_WR), .fire(fire)
  );

  evt_pend_track #(.N(N_EVT)) u_pend (
    .clk(clk), .rst_n(rst_n), .pulse(evt_pulse), .fire(fire),
    .after_clr(after_clr), .irq(irq_fast)
  );

  // every bit left after the clear lies above the cleared one,
  // so the lowest remaining bit is the next one at or above it
  evt_prio_enc #(.W(N_EVT), .IW(IW)) u_enc_next (
    .vec(after_clr), .found(nxt_found), .idx(nxt_idx)
  );

  evt_prio_enc #(.W(N_EVT), .IW(IW)) u_enc_new (
    .vec(evt_pulse), .found(new_found), .idx(new_idx)
  );

  evt_num_reg #(.IW(IW)) u_num (
    .clk(clk), .rst_n(rst_n), .fire(fire),
    .nxt_found(nxt_found), .nxt_idx(nxt_idx),
    .new_found(new_found), .new_idx(new_idx), .num_q(num_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (cmd == BUS_RD_NUM) begin
      bus_rdata <= DATA_W'(num_q);
    end else if (bus_valid && !bus_we) begin
      bus_rdata <= '0;
    end
  end

  // R7: a number read returns the register value one cycle later
  p_rd_num_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == BUS_RD_NUM) |=> (bus_rdata == DATA_W'($past(num_q))));

  // R8: reads of other addresses return zero
  p_rd_other_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_we && bus_addr != NUM_ADDR) |=> (bus_rdata == '0));

endmodule

// File: tb/test_evt_irq_ctrl.sv
module test_evt_irq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  evt_pulse = '0;
  logic        bus_valid = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_fast;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  evt_irq_ctrl i_evt_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse),
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_fast(irq_fast)
  );

  // ops: 0 idle, 1 clear write 0xD04, 2 read 0xD00, 3 write 0x800, 4 read 0xD04
  // row: {op[2:0], evt[7:0], exp_irq, exp_num[2:0], req[3:0]}
  localparam int NROW = 67;
  localparam logic [18:0] TBL [0:NROW-1] = '{
    {3'd2, 8'h00, 1'b0, 3'd1, 4'd7},   // R7 reset value
    {3'd0, 8'h20, 1'b1, 3'd0, 4'd2},   // R2 event 5
    {3'd2, 8'h00, 1'b1, 3'd1, 4'd3},   // R3 1 < 5 keeps
    {3'd0, 8'h04, 1'b1, 3'd0, 4'd1},   // R1 event 2
    {3'd2, 8'h00, 1'b1, 3'd1, 4'd3},
    {3'd1, 8'h00, 1'b1, 3'd0, 4'd4},   // R4
    {3'd1, 8'h00, 1'b1, 3'd0, 4'd4},
    {3'd1, 8'h00, 1'b1, 3'd0, 4'd4},
    {3'd2, 8'h00, 1'b1, 3'd1, 4'd4},
    {3'd1, 8'h00, 1'b1, 3'd0, 4'd5},   // R5 clears 2 -> 5
    {3'd2, 8'h00, 1'b1, 3'd5, 4'd5},
    {3'd0, 8'h08, 1'b1, 3'd0, 4'd3},   // event 3
    {3'd2, 8'h00, 1'b1, 3'd3, 4'd3},
    {3'd3, 8'h00, 1'b1, 3'd0, 4'd11},  // R11
    {3'd3, 8'h00, 1'b1, 3'd0, 4'd11},
    {3'd3, 8'h00, 1'b1, 3'd0, 4'd11},
    {3'd3, 8'h00, 1'b1, 3'd0, 4'd11},
    {3'd2, 8'h00, 1'b1, 3'd3, 4'd11},
    {3'd4, 8'h00, 1'b1, 3'd0, 4'd8},   // R8
    {3'd1, 8'h00, 1'b1, 3'd0, 4'd5},
    {3'd1, 8'h00, 1'b1, 3'd0, 4'd5},
    {3'd1, 8'h00, 1'b1, 3'd0, 4'd5},
    {3'd1, 8'h00, 1'b1, 3'd0, 4'd5},
    {3'd2, 8'h00, 1'b1, 3'd5, 4'd5},
    {3'd1, 8'h00, 1'b1, 3'd0, 4'd6},   // R6
    {3'd1, 8'h00, 1'b1, 3'd0, 4'd6},
    {3'd1, 8'h00, 1'b1, 3'd0, 4'd6},
    {3'd1, 8'h00, 1'b0, 3'd0, 4'd6},
    {3'd2, 8'h00, 1'b0, 3'd5, 4'd6},
    {3'd0, 8'h80, 1'b1, 3'd0, 4'd2},   // event 7
    {3'd2, 8'h00, 1'b1, 3'd5, 4'd3},
    {3'd1, 8'h00, 1'b1, 3'd0, 4'd6},
    {3'd1, 8'h00, 1'b1, 3'd0, 4'd6},
    {3'd1, 8'h00, 1'b1, 3'd0, 4'd6},
    {3'd1, 8'h00, 1'b0, 3'd0, 4'd6},
    {3'd2, 8'h00, 1'b0, 3'd5, 4'd6},
    {3'd0, 8'h01, 1'b1, 3'd0, 4'd2},   // event 0
    {3'd2, 8'h00, 1'b1, 3'd0, 4'd3},
    {3'd0, 8'h40, 1'b1, 3'd0, 4'd3},   // event 6 loads over a zero
    {3'd2, 8'h00, 1'b1, 3'd6, 4'd3},
    {3'd1, 8'h00, 1'b1, 3'd0, 4'd5},
    {3'd1, 8'h00, 1'b1, 3'd0, 4'd5},
    {3'd1, 8'h00, 1'b1, 3'd0, 4'd5},
    {3'd1, 8'h00, 1'b1, 3'd0, 4'd5},
    {3'd2, 8'h00, 1'b1, 3'd6, 4'd5},
    {3'd1, 8'h00, 1'b1, 3'd0, 4'd6},
    {3'd1, 8'h00, 1'b1, 3'd0, 4'd6},
    {3'd1, 8'h00, 1'b1, 3'd0, 4'd6},
    {3'd1, 8'h00, 1'b0, 3'd0, 4'd6},
    {3'd2, 8'h00, 1'b0, 3'd6, 4'd6},
    {3'd0, 8'h12, 1'b1, 3'd0, 4'd1},   // R1 events 1 and 4 together
    {3'd2, 8'h00, 1'b1, 3'd1, 4'd3},
    {3'd1, 8'h00, 1'b1, 3'd0, 4'd9},   // R9
    {3'd1, 8'h00, 1'b1, 3'd0, 4'd9},
    {3'd1, 8'h00, 1'b1, 3'd0, 4'd9},
    {3'd1, 8'h02, 1'b1, 3'd0, 4'd9},   // clear 1 with event 1 again
    {3'd2, 8'h00, 1'b1, 3'd1, 4'd9},
    {3'd1, 8'h00, 1'b1, 3'd0, 4'd9},
    {3'd1, 8'h00, 1'b1, 3'd0, 4'd9},
    {3'd1, 8'h00, 1'b1, 3'd0, 4'd9},
    {3'd1, 8'h00, 1'b1, 3'd0, 4'd9},
    {3'd2, 8'h00, 1'b1, 3'd4, 4'd9},
    {3'd1, 8'h00, 1'b1, 3'd0, 4'd9},
    {3'd1, 8'h00, 1'b1, 3'd0, 4'd9},
    {3'd1, 8'h00, 1'b1, 3'd0, 4'd9},
    {3'd1, 8'h00, 1'b0, 3'd0, 4'd9},
    {3'd2, 8'h00, 1'b0, 3'd4, 4'd9}
  };

  task automatic step(input logic [2:0] op, input logic [7:0] evt);
    evt_pulse = evt;
    bus_valid = (op != 3'd0);
    bus_we    = (op == 3'd1) || (op == 3'd3);
    case (op)
      3'd1, 3'd4: bus_addr = 12'hD04;
      3'd2:       bus_addr = 12'hD00;
      3'd3:       bus_addr = 12'h800;
      default:    bus_addr = 12'h000;
    endcase
    bus_wdata = 32'hA5A5_0003;
    @(negedge clk);
    evt_pulse = '0;
    bus_valid = 1'b0;
    bus_we    = 1'b0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    checks++;
    if (irq_fast !== exp) begin
      failures++;
      $display("FAIL %s irq actual=%0b expected=%0b", tag, irq_fast, exp);
    end
  endtask

  task automatic chk_rd(input logic [31:0] exp, input string tag);
    checks++;
    if (bus_rdata !== exp) begin
      failures++;
      $display("FAIL %s rdata actual=%h expected=%h", tag, bus_rdata, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_irq(1'b0, "R10");
    for (int r = 0; r < NROW; r++) begin
      logic [18:0] row;
      string tag;
      row = TBL[r];
      tag = $sformatf("R%0d row%0d", row[3:0], r);
      step(row[18:16], row[15:8]);
      chk_irq(row[7], tag);
      if (row[18:16] == 3'd2) chk_rd({29'd0, row[6:4]}, tag);
      if (row[18:16] == 3'd4) chk_rd(32'd0, tag);
    end

    // R10 directed: reset with an event pending and the count partway
    step(3'd0, 8'h08);
    step(3'd1, 8'h00);
    step(3'd1, 8'h00);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk_irq(1'b0, "R10 after reset");
    step(3'd2, 8'h00);
    chk_rd(32'd1, "R10 number after reset");
    step(3'd0, 8'h14);
    chk_irq(1'b1, "R10 events 2,4");
    step(3'd1, 8'h00);
    step(3'd1, 8'h00);
    step(3'd1, 8'h00);
    step(3'd2, 8'h00);
    chk_rd(32'd1, "R10 count was cleared");
    step(3'd1, 8'h00);
    step(3'd2, 8'h00);
    chk_rd(32'd4, "R10 fourth write after reset");
    repeat (4) step(3'd1, 8'h00);
    chk_irq(1'b0, "R10 drained");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule